// File: doc/BRIEF.md
# Prescaled Pulse Width Modulator Channel

This block produces one pulse-width-modulated output from a single clock. A small down counter divides the clock by a programmable factor from 1 to 64, and each of its expiries advances a 10-bit up counter. The up counter runs from zero to a programmed period value and wraps there. The output is high while the counter is below a programmed duty value, so one cycle of the waveform is `period+1` counter steps long and the high part is `duty` steps long.

Software sets three registers through a plain write port: a control word that holds the prescale value and a shutdown-mode bit, a duty register, and a period register. New duty and period values wait in the registers and take effect only at the next wrap, so a cycle that has already started is never cut short. An enable input stands in for the channel's clock gate. When the enable is removed the channel stops in one of two ways, chosen by the mode bit. In abrupt mode it halts at once and rewinds its counters. In graceful mode it first finishes the cycle in progress. While stopped, the output is low and the counters hold their values.

Top module: `pwm_chan`

## Requirements
- R1: After reset the duty register is 0, the period register is 4, the prescale value is 0 and abrupt mode is selected. The output is low until a nonzero duty is written. With only duty = 2 written, the output is high for 2 clocks and low for 3 clocks.
- R2: Each counter step lasts `prescale+1` clocks. The prescale value is control bits [5:0], so the range is 1 (value 0) to 64 (value 63).
- R3: One cycle lasts `period+1` steps. The output is high for the first `duty` steps and low for the rest. The counter never exceeds the active period value.
- R4: A duty value of 0 holds the output low.
- R5: A period value below the duty value holds the output high while the channel runs.
- R6: Duty and period writes made during a cycle leave that cycle unchanged. They apply from the next wrap.
- R7: Abrupt mode is control bit 6 = 0. When the enable is sampled low, the output goes low on the next clock. The up counter returns to 0 and the prescaler reloads its register value.
- R8: Graceful mode is control bit 6 = 1. When the enable is sampled low, the current cycle runs to its wrap before the channel stops.
- R9: While stopped, the output stays low and both counters hold their values. When the enable returns, the output reflects the held counter state on the next clock.
- R10: Writes select their target with a 2-bit code: 0 = control, 1 = duty, 2 = period. Code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, which also drives the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable (the clock-gate stand-in) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 = control, 1 = duty, 2 = period |
| wr_data | input | CNT_W (10) | Write data. For control: [5:0] = prescale, [6] = graceful mode |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest situation to reach from the ports is a shutdown that lands partway through a high pulse. It is hard because the bench cannot see the counter phase. The stimulus waits until it observes a rising edge on the output, counts a known number of clocks, and then drops the enable. It then measures the length of the truncated or completed pulse and the length of the first pulse after the enable returns, which reveals whether the counters were rewound or held. The same edge-locked approach lands a duty write in the middle of a high pulse, which tests that new values wait until the cycle boundary.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
    localparam int PS_W_DEF    = 6;
    localparam int CNT_W_DEF   = 10;
    localparam int RST_PER_DEF = 4;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_st_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DUTY = 2'd1,
        SEL_PER  = 2'd2,
        SEL_NONE = 2'd3
    } wsel_t;

    function automatic logic is_live(run_st_t s);
        return s != ST_STOP;
    endfunction
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int PS_W    = PS_W_DEF,
    parameter int CNT_W   = CNT_W_DEF,
    parameter int RST_PER = RST_PER_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [PS_W-1:0]  ps_val,
    output logic             grace,
    output logic [CNT_W-1:0] duty_r,
    output logic [CNT_W-1:0] per_r
);
    localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(RST_PER);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_val <= '0;
            grace  <= 1'b0;
            duty_r <= '0;
            per_r  <= PER_INIT;
        end else if (wr_en) begin
            case (wsel_t'(wr_sel))
                SEL_CTRL: begin
                    ps_val <= wr_data[PS_W-1:0];
                    grace  <= wr_data[PS_W];
                end
                SEL_DUTY: duty_r <= wr_data;
                SEL_PER:  per_r  <= wr_data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int PS_W = PS_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            reload,
    input  logic [PS_W-1:0] load_val,
    output logic            tick,
    output logic [PS_W-1:0] ps_cnt
);
    assign tick = adv && (ps_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_cnt <= '0;
        end else if (reload) begin
            ps_cnt <= load_val;
        end else if (adv) begin
            if (ps_cnt == '0) ps_cnt <= load_val;
            else              ps_cnt <= ps_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int RST_PER = RST_PER_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [CNT_W-1:0] per_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_duty,
    output logic [CNT_W-1:0] act_per,
    output logic             wrap,
    output logic             hi
);
    localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(RST_PER);

    // the next step would reach period+1, so the count restarts instead
    assign wrap = tick && (cnt == act_per);
    assign hi   = cnt < act_duty;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            act_duty <= '0;
            act_per  <= PER_INIT;
        end else if (reload || wrap) begin
            cnt      <= '0;
            act_duty <= duty_in;
            act_per  <= per_in;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int PS_W    = PS_W_DEF,
    parameter int CNT_W   = CNT_W_DEF,
    parameter int RST_PER = RST_PER_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out
);
    logic [PS_W-1:0]  ps_val;
    logic             grace;
    logic [CNT_W-1:0] duty_r, per_r;
    logic [PS_W-1:0]  ps_cnt;
    logic [CNT_W-1:0] cnt, act_duty, act_per;
    logic             tick, wrap, hi;
    logic             adv, reload;
    run_st_t          state, state_nx;

    pwm_regs #(.PS_W(PS_W), .CNT_W(CNT_W), .RST_PER(RST_PER)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ps_val(ps_val), .grace(grace), .duty_r(duty_r), .per_r(per_r)
    );

    pwm_prescaler #(.PS_W(PS_W)) u_ps (
        .clk(clk), .rst(rst), .adv(adv), .reload(reload), .load_val(ps_val),
        .tick(tick), .ps_cnt(ps_cnt)
    );

    pwm_counter #(.CNT_W(CNT_W), .RST_PER(RST_PER)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .reload(reload),
        .duty_in(duty_r), .per_in(per_r),
        .cnt(cnt), .act_duty(act_duty), .act_per(act_per), .wrap(wrap), .hi(hi)
    );

    assign reload = (state == ST_RUN) && !en && !grace;
    assign adv    = is_live(state) && !reload;

    always_comb begin
        state_nx = state;
        case (state)
            ST_STOP:  if (en) state_nx = ST_RUN;
            ST_RUN: begin
                if (!en) begin
                    if (!grace || wrap) state_nx = ST_STOP;
                    else                state_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (en)        state_nx = ST_RUN;
                else if (wrap) state_nx = ST_STOP;
            end
            default: state_nx = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_STOP;
        else     state <= state_nx;
    end

    assign pwm_out = is_live(state) && hi;
endmodule

// File: rtl/pwm_chan_chk.sv
`timescale 1ns/1ps
module pwm_chan_chk
    import pwm_pkg::*;
#(
    parameter int PS_W    = PS_W_DEF,
    parameter int CNT_W   = CNT_W_DEF,
    parameter int RST_PER = RST_PER_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             grace,
    input run_st_t          state,
    input logic [CNT_W-1:0] cnt,
    input logic [PS_W-1:0]  ps_cnt,
    input logic [PS_W-1:0]  ps_val,
    input logic [CNT_W-1:0] act_duty,
    input logic [CNT_W-1:0] act_per,
    input logic [CNT_W-1:0] duty_r,
    input logic [CNT_W-1:0] per_r,
    input logic             wrap,
    input logic             reload,
    input logic             pwm_out
);
    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> (duty_r == '0 && per_r == CNT_W'(RST_PER) && ps_val == '0 && !grace && !pwm_out)); // R1

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        cnt <= act_per); // R3

    AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (act_duty == '0) |-> !pwm_out); // R4

    AST_PER_BELOW_DUTY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state != ST_STOP && act_per < act_duty) |-> pwm_out); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !reload) |=> ($stable(act_duty) && $stable(act_per))); // R6

    AST_ABRUPT_STOP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !en && !grace) |=> (state == ST_STOP && cnt == '0 && !pwm_out)); // R7

    AST_GRACE_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !en && grace && !wrap) |=> (state == ST_DRAIN)); // R8

    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |=> ($stable(cnt) && $stable(ps_cnt))); // R9
endmodule

bind pwm_chan pwm_chan_chk #(.PS_W(PS_W), .CNT_W(CNT_W), .RST_PER(RST_PER)) u_chk (
    .clk(clk), .rst(rst), .en(en), .grace(grace), .state(state),
    .cnt(cnt), .ps_cnt(ps_cnt), .ps_val(ps_val), .act_duty(act_duty), .act_per(act_per),
    .duty_r(duty_r), .per_r(per_r), .wrap(wrap), .reload(reload), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_chan.sv
`timescale 1ns/1ps
module sim_pwm_chan;
    localparam int CNT_W = 10;
    localparam int LIM   = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic pwm_out;

    always #5 clk = ~clk;

    pwm_chan u0 (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_done = 0;
    int n_chk  = 0;
    int n_bad  = 0;
    bit finished = 1'b0;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int sel, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = CNT_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // returns at the first negedge sample where the output equals v
    task automatic wait_level(logic v);
        int k = 0;
        @(negedge clk);
        while (pwm_out !== v && k < LIM) begin
            k++;
            @(negedge clk);
        end
    endtask

    task automatic count_level(logic v, int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out === v) c++;
        end
    endtask

    // length of the high run that began at the current sample
    task automatic high_len(output int h);
        h = 1;
        forever begin
            @(negedge clk);
            if (pwm_out !== 1'b1 || h >= LIM) break;
            h++;
        end
    endtask

    task automatic expect_pulse(int hi, int lo, string tag);
        exp_t e;
        int d;
        e.hi = hi; e.lo = lo; e.tag = tag;
        d = n_done;
        q.push_back(e);
        wait (n_done == d + 1);
    endtask

    // monitor: skip one rising edge, then measure one high and one low run
    initial begin
        forever begin
            exp_t e;
            int hi, lo;
            wait (q.size() > 0);
            e = q[0];
            wait_level(1'b0); wait_level(1'b1);
            wait_level(1'b0); wait_level(1'b1);
            hi = 0;
            while (pwm_out === 1'b1 && hi < LIM) begin hi++; @(negedge clk); end
            lo = 0;
            while (pwm_out === 1'b0 && lo < LIM) begin lo++; @(negedge clk); end
            check(hi == e.hi, {e.tag, " high clocks"}, hi, e.hi);
            check(lo == e.lo, {e.tag, " low clocks"}, lo, e.lo);
            void'(q.pop_front());
            n_done++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int c, h, k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_out === 1'b0, "R1 output low after reset", int'(pwm_out), 0);
        en = 1'b1;
        count_level(1'b0, 40, c);
        check(c == 40, "R1 low with reset duty", c, 40);

        // R1: reset period 4 and prescale 0
        wr(1, 2);
        expect_pulse(2, 3, "R1 reset period");

        // R3: several duty and period pairs
        wr(2, 9); wr(1, 3);
        expect_pulse(3, 7, "R3 duty3 per9");
        wr(2, 3); wr(1, 1);
        expect_pulse(1, 3, "R3 duty1 per3");

        // R2: prescaling
        wr(0, 2); wr(2, 4); wr(1, 2);
        expect_pulse(6, 9, "R2 prescale2");
        wr(0, 63); wr(2, 1); wr(1, 1);
        expect_pulse(64, 64, "R2 prescale63");

        // R10: select code 3 must not change duty or period
        wr(0, 0); wr(2, 5); wr(1, 2);
        wr(3, 1);
        expect_pulse(2, 4, "R10 code3 ignored");

        // R4: zero duty
        wr(1, 0);
        repeat (40) @(negedge clk);
        count_level(1'b0, 40, c);
        check(c == 40, "R4 zero duty low", c, 40);

        // R5: period below duty
        wr(2, 2); wr(1, 5);
        repeat (40) @(negedge clk);
        count_level(1'b1, 40, c);
        check(c == 40, "R5 constant high", c, 40);
        // R9: stopped output is low even in that setting
        en = 1'b0;
        repeat (2) @(negedge clk);
        count_level(1'b0, 20, c);
        check(c == 20, "R9 low while stopped", c, 20);
        en = 1'b1;

        // R6: duty write during a high pulse applies at the next wrap
        wr(2, 9); wr(1, 4);
        repeat (30) @(negedge clk);
        wait_level(1'b0); wait_level(1'b1);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = CNT_W'(1);
        h = 1;
        forever begin
            @(negedge clk);
            wr_en = 1'b0;
            if (pwm_out !== 1'b1 || h >= LIM) break;
            h++;
        end
        check(h == 4, "R6 current pulse kept", h, 4);
        expect_pulse(1, 9, "R6 new duty after wrap");

        // R7: abrupt stop in the first high clock
        wr(0, 0); wr(2, 5); wr(1, 2);
        repeat (30) @(negedge clk);
        wait_level(1'b0); wait_level(1'b1);
        en = 1'b0;
        high_len(h);
        check(h == 1, "R7 abrupt cut", h, 1);
        count_level(1'b0, 30, c);
        check(c == 30, "R7 low after abrupt stop", c, 30);
        en = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (pwm_out !== 1'b1 && k < LIM);
        check(k == 1, "R9 restart latency after abrupt", k, 1);
        high_len(h);
        check(h == 2, "R7 rewound first pulse", h, 2);

        // R8: graceful stop two clocks into a high pulse
        wr(0, 64 + 1); wr(2, 7); wr(1, 3);
        repeat (40) @(negedge clk);
        wait_level(1'b0); wait_level(1'b1);
        h = 1;
        forever begin
            @(negedge clk);
            if (pwm_out !== 1'b1 || h >= LIM) break;
            h++;
            if (h == 2) en = 1'b0;
        end
        check(h == 6, "R8 pulse completed", h, 6);
        count_level(1'b0, 60, c);
        check(c == 60, "R8 stopped after cycle end", c, 60);
        en = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (pwm_out !== 1'b1 && k < LIM);
        check(k == 1, "R9 restart latency after graceful", k, 1);
        high_len(h);
        check(h == 6, "R9 held counters resume", h, 6);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule